// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block turns the status of a 16550-style serial port into a single interrupt request and an identification byte that the host reads to learn why it was interrupted. It watches five interrupt sources (receiver line errors, character timeout, received data, transmitter holding register empty and modem status changes). It picks the most urgent source that is both enabled and active, and encodes it in the low nibble of the identification byte. The two top bits of that byte show whether the FIFOs are on.

The block owns the 4-bit interrupt enable register and the hidden transmitter-empty pending flag. That flag is needed because the holding-register-empty condition is a level, yet it must stop interrupting once the host has acknowledged it. Reading the identification byte gives that acknowledgement. Rewriting the enable register while the holding register is empty arms the flag again, as does a transmitter-empty event from the shifter. The identification byte and the request line are registered, and both are recomputed from the current status on every clock.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification byte is 0x01, the interrupt request is low and the enable register reads 0.
- R2: When several sources are active, the identification code is that of the highest one in this order: line status, character timeout, received data, holding register empty, modem status.
- R3: The low nibble of the identification byte is 0x6 for line status, 0xC for character timeout, 0x4 for received data, 0x2 for holding register empty, 0x0 for modem status and 0x1 for nothing pending. The request is high exactly when that nibble is not 0x1.
- R4: A line status interrupt needs enable bit 2 and at least one of the four error flags (overrun, parity, framing, break).
- R5: A received-data interrupt needs enable bit 0 and data ready. With FIFOs enabled it also needs receive count >= trigger level; otherwise the source is treated as inactive and lower sources may win.
- R6: A pending character timeout is reported whenever the enable register is non-zero, regardless of which enable bits are set.
- R7: Bits 7:6 of the identification byte are 11 while FIFOs are enabled and 00 otherwise. Bits 5:4 are always 0.
- R8: The transmitter-empty pending flag is cleared by a read of the identification byte and by a load of the holding register.
- R9: The pending flag is set by a transmitter-empty event, or by an enable-register write while the holding register is empty. A set in the same cycle as a clear wins. The flag interrupts only with enable bit 1.
- R10: While the enable register is zero, the request is low and the low nibble reads 0x1.
- R11: An enable-register write stores only the low 4 bits of the written byte. Without a write the register holds its value.
- R12: The outputs after a clock edge reflect the status inputs and internal state sampled at that edge, so any change appears exactly one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_wr_i | input | 1 | Write strobe for the enable register |
| en_wdata_i | input | 8 | Byte written to the enable register |
| id_rd_i | input | 1 | Host read strobe on the identification byte |
| tx_load_i | input | 1 | Host load of the holding register |
| tx_empty_evt_i | input | 1 | Pulse: the transmitter has emptied the holding register |
| hold_empty_i | input | 1 | Level: the holding register is currently empty |
| err_flags_i | input | 4 | Overrun, parity, framing and break flags |
| data_ready_i | input | 1 | Receive data available |
| timeout_i | input | 1 | Character-timeout pending |
| fifo_en_i | input | 1 | FIFOs enabled |
| rx_count_i | input | CNT_W | Receive FIFO fill count |
| rx_trig_i | input | CNT_W | Receive FIFO trigger level |
| msr_delta_i | input | 4 | Modem-status delta bits |
| enable_o | output | 4 | Current enable register |
| ident_o | output | 8 | Identification byte |
| irq_o | output | 1 | Interrupt request |

## Verification
Random status words are applied with the error and delta flags biased toward zero, so that each of the five sources wins often, including cases where data is ready but the FIFO count sits just below or at the trigger level. Directed sequences cover the following:
- arming the holding-empty flag by an enable write, then clearing it with an identification read, which separates the hidden flag from the level input;
- a timeout with only the modem enable set, which shows that the timeout is not gated by an enable bit;
- error flags with a zero enable register, which shows the forced-low request.

Every vector is compared one cycle after it is applied, so an unregistered or double-registered output shows up as a mismatch.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [3:0] {
        ID_MODEM   = 4'h0,
        ID_NONE    = 4'h1,
        ID_THRE    = 4'h2,
        ID_RXDATA  = 4'h4,
        ID_LINE    = 4'h6,
        ID_TIMEOUT = 4'hC
    } irq_id_e;

    localparam int EN_RXDATA = 0;
    localparam int EN_THRE   = 1;
    localparam int EN_LINE   = 2;
    localparam int EN_MODEM  = 3;
    localparam int EN_W      = 4;
    localparam int NUM_SRC   = 5;

    typedef struct packed {
        logic [EN_W-1:0] enable;
        logic [7:0]      ident;
        logic            irq;
    } ident_state_t;

endpackage

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [EN_W-1:0]  enable_i,
    input  logic [3:0]       err_flags_i,
    input  logic             data_ready_i,
    input  logic             timeout_i,
    input  logic             fifo_en_i,
    input  logic [CNT_W-1:0] rx_count_i,
    input  logic [CNT_W-1:0] rx_trig_i,
    input  logic             thre_pend_i,
    input  logic [3:0]       msr_delta_i,
    output irq_id_e          id_o
);

    logic    [NUM_SRC-1:0] req;
    irq_id_e               code [NUM_SRC];
    logic                  rx_level_ok;

    assign rx_level_ok = !fifo_en_i || (rx_count_i >= rx_trig_i);

    // Index 0 is the most urgent source.
    assign req[0] = enable_i[EN_LINE] && (|err_flags_i);
    assign req[1] = timeout_i;
    assign req[2] = enable_i[EN_RXDATA] && data_ready_i && rx_level_ok;
    assign req[3] = enable_i[EN_THRE] && thre_pend_i;
    assign req[4] = enable_i[EN_MODEM] && (|msr_delta_i);

    assign code[0] = ID_LINE;
    assign code[1] = ID_TIMEOUT;
    assign code[2] = ID_RXDATA;
    assign code[3] = ID_THRE;
    assign code[4] = ID_MODEM;

    always_comb begin
        id_o = ID_NONE;
        if (enable_i != '0) begin
            for (int i = NUM_SRC - 1; i >= 0; i--) begin
                if (req[i]) id_o = code[i];
            end
        end
    end

endmodule

// File: rtl/uart_irq_thre_pend.sv
module uart_irq_thre_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);

    logic pend_d, pend_q;

    always_comb begin
        pend_d = set_i ? 1'b1 : (clr_i ? 1'b0 : pend_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr_i,
    input  logic [7:0]       en_wdata_i,
    input  logic             id_rd_i,
    input  logic             tx_load_i,
    input  logic             tx_empty_evt_i,
    input  logic             hold_empty_i,
    input  logic [3:0]       err_flags_i,
    input  logic             data_ready_i,
    input  logic             timeout_i,
    input  logic             fifo_en_i,
    input  logic [CNT_W-1:0] rx_count_i,
    input  logic [CNT_W-1:0] rx_trig_i,
    input  logic [3:0]       msr_delta_i,
    output logic [EN_W-1:0]  enable_o,
    output logic [7:0]       ident_o,
    output logic             irq_o
);

    ident_state_t st_d, st_q;
    irq_id_e      id_now;
    logic         thre_pend;
    logic         pend_set, pend_clr;

    assign pend_set = tx_empty_evt_i || (en_wr_i && hold_empty_i);
    assign pend_clr = id_rd_i || tx_load_i;

    uart_irq_thre_pend u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (pend_set),
        .clr_i  (pend_clr),
        .pend_o (thre_pend)
    );

    uart_irq_prio #(.CNT_W(CNT_W)) u_prio (
        .enable_i     (st_q.enable),
        .err_flags_i  (err_flags_i),
        .data_ready_i (data_ready_i),
        .timeout_i    (timeout_i),
        .fifo_en_i    (fifo_en_i),
        .rx_count_i   (rx_count_i),
        .rx_trig_i    (rx_trig_i),
        .thre_pend_i  (thre_pend),
        .msr_delta_i  (msr_delta_i),
        .id_o         (id_now)
    );

    always_comb begin
        st_d = st_q;
        if (en_wr_i) st_d.enable = en_wdata_i[EN_W-1:0];
        st_d.ident = {fifo_en_i ? 2'b11 : 2'b00, 2'b00, id_now};
        st_d.irq   = (id_now != ID_NONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.enable <= '0;
            st_q.ident  <= 8'h01;
            st_q.irq    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign enable_o = st_q.enable;
    assign ident_o  = st_q.ident;
    assign irq_o    = st_q.irq;

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en_wr_i,
    input logic [3:0] err_flags_i,
    input logic       timeout_i,
    input logic       fifo_en_i,
    input logic [3:0] enable_o,
    input logic [7:0] ident_o,
    input logic       irq_o
);

    a_r10_zero_enable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_o == 4'h0) |=> (!irq_o && ident_o[3:0] == 4'h1));

    a_r7_fifo_bits: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_en_i |=> (ident_o[7:6] == 2'b11));

    a_r4_line_status_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_o[2] && (|err_flags_i)) |=> (ident_o[3:0] == 4'h6 && irq_o));

    a_r2_timeout_over_lower: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_i && enable_o != 4'h0 && !(enable_o[2] && (|err_flags_i)))
        |=> (ident_o[3:0] == 4'hC));

    a_r11_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !en_wr_i |=> $stable(enable_o));

endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_wr_i     (en_wr_i),
    .err_flags_i (err_flags_i),
    .timeout_i   (timeout_i),
    .fifo_en_i   (fifo_en_i),
    .enable_o    (enable_o),
    .ident_o     (ident_o),
    .irq_o       (irq_o)
);

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb_top;

    localparam int CW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_wr = 0, id_rd = 0, tx_load = 0, tx_evt = 0, hold_empty = 0;
    logic [7:0] en_wdata = 0;
    logic [3:0] err = 0, delta = 0;
    logic dr = 0, tmo = 0, fen = 0;
    logic [CW-1:0] cnt = 0, trig = 1;
    logic [3:0] enable_o;
    logic [7:0] ident_o;
    logic irq_o;

    int vectors = 0;
    int fails = 0;
    logic [3:0] m_en = 0;
    logic m_pend = 0;

    always #5 clk = ~clk;

    uart_irq_ident dut_i (
        .clk(clk), .rst_n(rst_n), .en_wr_i(en_wr), .en_wdata_i(en_wdata),
        .id_rd_i(id_rd), .tx_load_i(tx_load), .tx_empty_evt_i(tx_evt),
        .hold_empty_i(hold_empty), .err_flags_i(err), .data_ready_i(dr),
        .timeout_i(tmo), .fifo_en_i(fen), .rx_count_i(cnt), .rx_trig_i(trig),
        .msr_delta_i(delta), .enable_o(enable_o), .ident_o(ident_o), .irq_o(irq_o)
    );

    // Expected identification byte from the requirements (R2..R7, R10).
    function automatic logic [7:0] exp_ident(logic [3:0] en, logic pend);
        logic [3:0] c;
        if (en == 4'h0)                                  c = 4'h1; // R10
        else if (en[2] && (|err))                        c = 4'h6; // R4
        else if (tmo)                                    c = 4'hC; // R6
        else if (en[0] && dr && (!fen || cnt >= trig))   c = 4'h4; // R5
        else if (en[1] && pend)                          c = 4'h2; // R9
        else if (en[3] && (|delta))                      c = 4'h0;
        else                                             c = 4'h1;
        return {fen ? 2'b11 : 2'b00, 2'b00, c};                   // R7
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // One clock: inputs already driven; compare after the edge (R12).
    task automatic step(string tag);
        logic [7:0] e_id;
        logic [3:0] n_en;
        logic       n_pend;
        e_id   = exp_ident(m_en, m_pend);
        n_en   = en_wr ? en_wdata[3:0] : m_en;                       // R11
        n_pend = (tx_evt || (en_wr && hold_empty)) ? 1'b1 :           // R9
                 ((id_rd || tx_load) ? 1'b0 : m_pend);                // R8
        @(posedge clk);
        #1;
        m_en   = n_en;
        m_pend = n_pend;
        check({tag, " R12 ident"}, ident_o, e_id);
        check({tag, " R3 irq"}, {7'd0, irq_o}, {7'd0, e_id[3:0] != 4'h1});
        check({tag, " R11 enable"}, {4'd0, enable_o}, {4'd0, m_en});
        @(negedge clk);
        en_wr = 0; id_rd = 0; tx_load = 0; tx_evt = 0;
    endtask

    task automatic clear_status();
        err = 0; delta = 0; dr = 0; tmo = 0; fen = 0; cnt = 0; trig = 1; hold_empty = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #22;
        // R1: reset state
        check("R1 ident", ident_o, 8'h01);
        check("R1 irq", {7'd0, irq_o}, 8'h00);
        check("R1 enable", {4'd0, enable_o}, 8'h00);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R11: only low nibble stored; R9: write while holding empty arms flag
        hold_empty = 1; en_wr = 1; en_wdata = 8'hF2;
        step("R11 write");
        hold_empty = 0;
        step("R9 armed");
        step("R9 reported");
        // R8: identification read clears the flag
        id_rd = 1;
        step("R8 read");
        step("R8 cleared");
        // R9 event set, R8 holding load clears
        tx_evt = 1;
        step("R9 event");
        step("R9 event seen");
        tx_load = 1;
        step("R8 load");
        step("R8 load seen");
        // R9: same-cycle set and clear -> set wins
        tx_evt = 1; id_rd = 1;
        step("R9 collide");
        step("R9 collide seen");

        // R6: timeout with only modem enable
        en_wr = 1; en_wdata = 8'h08; step("R6 setup");
        tmo = 1; step("R6 tmo"); step("R6 tmo seen");
        tmo = 0;
        // R5: FIFO trigger gating
        en_wr = 1; en_wdata = 8'h01; step("R5 setup");
        fen = 1; dr = 1; trig = 4; cnt = 3; step("R5 below"); step("R5 below seen");
        cnt = 4; step("R5 at"); step("R5 at seen");
        fen = 0; cnt = 0; step("R5 nofifo"); step("R5 nofifo seen");
        // R10: zero enable with all sources active
        en_wr = 1; en_wdata = 8'hF0; err = 4'h2; tmo = 1; delta = 4'h1;
        step("R10 zero"); step("R10 zero seen"); step("R10 zero held");
        // R2: all active -> line status
        en_wr = 1; en_wdata = 8'h0F; step("R2 all"); step("R2 all seen");
        // R4: line status needs its enable
        en_wr = 1; en_wdata = 8'h0B; tmo = 0; dr = 0; step("R4 off"); step("R4 off seen");
        clear_status();

        // Random mix (R2, R3, R5, R12)
        for (int i = 0; i < 3000; i++) begin
            en_wr      = ($urandom % 8) == 0;
            en_wdata   = 8'($urandom);
            id_rd      = ($urandom % 6) == 0;
            tx_load    = ($urandom % 8) == 0;
            tx_evt     = ($urandom % 5) == 0;
            hold_empty = 1'($urandom);
            err        = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
            delta      = (($urandom % 3) == 0) ? 4'($urandom) : 4'h0;
            dr         = 1'($urandom);
            tmo        = ($urandom % 6) == 0;
            fen        = 1'($urandom);
            cnt        = CW'($urandom % 17);
            case ($urandom % 4)
                0: trig = 1;
                1: trig = 4;
                2: trig = 8;
                default: trig = 14;
            endcase
            step("R2 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule